// File: doc/BRIEF.md
# Sideband Bit Trigger Unit

This block watches the per-beat sideband user bus that travels with a sample stream and turns chosen bits of it into two trigger events. The first event commits a pending configuration. The second event aligns the frame timing and starts capture. Each of the two channels has its own programmed settings:
- which single sideband bit it watches;
- whether it reacts to a low level, a high level, a rising edge or a falling edge of that bit;
- whether it is off, fires once per arming, or fires on every match.

A built-in ordering rule makes sure the frame-alignment event can only happen after a configuration commit. A frame-alignment match that arrives while no commit is waiting is dropped. Each channel also keeps a sticky status flag that software clears.

The unit sits next to the stream input of a capture scheduler. The commit pulse tells the configuration store to swap in the shadow settings. The align pulse restarts the frame and slot counters. Register decoding and the configuration memories live elsewhere.

Top module: `tuser_trig_unit`

## Requirements
- R1: Each channel watches only the sideband bit whose index is on its select input. The other sideband bits have no effect on that channel.
- R2: Condition code 0 matches on every valid beat where the selected bit is 0. Condition code 1 matches on every valid beat where the selected bit is 1.
- R3: Condition code 2 matches a valid beat where the selected bit is 1 and was 0 on the previous valid beat. Condition code 3 matches the opposite transition. The remembered beat is all zeros after reset, and it is updated only on valid beats.
- R4: When the stream valid input is low, the sideband bus is ignored. No trigger fires from it and the remembered beat does not change.
- R5: Mode code 0 and mode code 3 disable a channel. Mode code 2 fires on every matching beat.
- R6: Mode code 1 fires only while the channel is armed, and firing disarms it. The channel is disarmed after reset. A pulse on the arm input arms it. An arm pulse in the same cycle as a firing beat leaves the channel armed.
- R7: A firing sets the channel's status flag, and the flag stays set until the clear input is high. If a clear and a firing happen in the same cycle, the flag ends up set.
- R8: The commit and align outputs are one-cycle pulses. Each is high in the cycle after the beat on which its channel fired.
- R9: A commit enters the awaiting-align state. A frame-init match outside that state is ignored: it produces no align pulse, does not set the status flag and does not use up the arming. An align pulse returns the unit to waiting for a commit.
- R10: If the update and frame-init channels both match on one beat while awaiting align, only the commit is issued. The frame-init match on that beat is ignored.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Stream beat valid |
| s_tuser | input | TUSER_W | Sideband bus of the stream |
| upd_sel | input | IDX_W | Bit index watched by the update channel |
| upd_cond | input | 2 | Update condition: 0 low, 1 high, 2 rise, 3 fall |
| upd_mode | input | 2 | Update mode: 0 off, 1 single-shot, 2 continuous, 3 off |
| upd_arm | input | 1 | Arm pulse for the update channel |
| upd_clr | input | 1 | Clears the update status flag |
| fin_sel | input | IDX_W | Bit index watched by the frame-init channel |
| fin_cond | input | 2 | Frame-init condition, same coding as upd_cond |
| fin_mode | input | 2 | Frame-init mode, same coding as upd_mode |
| fin_arm | input | 1 | Arm pulse for the frame-init channel |
| fin_clr | input | 1 | Clears the frame-init status flag |
| commit_o | output | 1 | Configuration commit pulse |
| align_o | output | 1 | Frame alignment pulse |
| await_align_o | output | 1 | High while a commit waits for its alignment |
| upd_status_o | output | 1 | Sticky update event flag |
| fin_status_o | output | 1 | Sticky frame-init event flag |
| upd_armed_o | output | 1 | Update channel armed |
| fin_armed_o | output | 1 | Frame-init channel armed |

## Verification
A remembered beat that is stale or updated on an invalid beat shows up as a missing or extra commit pulse on the next valid beat whose selected bit changes. A sequencer that is in the wrong state shows up one cycle after a frame-init beat: an align pulse appears when none should, or a commit is not followed by an align. Errors in the arming and status flags show up on the armed and status outputs right after the edge that should have changed them. Each such error is therefore visible within one clock of the stimulus that exposes it.

// File: rtl/tuser_trig_pkg.sv
package tuser_trig_pkg;

    typedef enum logic [1:0] {
        CND_LOW  = 2'd0,
        CND_HIGH = 2'd1,
        CND_RISE = 2'd2,
        CND_FALL = 2'd3
    } cond_e;

    typedef enum logic [1:0] {
        MD_OFF  = 2'd0,
        MD_ONCE = 2'd1,
        MD_CONT = 2'd2,
        MD_RSVD = 2'd3
    } mode_e;

    typedef enum logic {
        SQ_WAIT_UPD = 1'b0,
        SQ_WAIT_FIN = 1'b1
    } seq_e;

    typedef struct packed {
        logic armed;
        logic status;
    } chan_st_t;

    typedef struct packed {
        seq_e st;
        logic commit;
        logic align;
    } seq_st_t;

endpackage

// File: rtl/tuser_bit_match.sv
module tuser_bit_match
    import tuser_trig_pkg::*;
#(
    parameter  int TUSER_W = 8,
    localparam int IDX_W   = (TUSER_W > 1) ? $clog2(TUSER_W) : 1
) (
    input  logic               valid,
    input  logic [TUSER_W-1:0] tuser,
    input  logic [TUSER_W-1:0] prev_tuser,
    input  logic [IDX_W-1:0]   sel,
    input  logic [1:0]         cond,
    output logic               hit
);
    localparam logic [IDX_W:0] LIMIT = TUSER_W[IDX_W:0];

    logic cur_bit;
    logic old_bit;

    always_comb begin
        cur_bit = 1'b0;
        old_bit = 1'b0;
        if ({1'b0, sel} < LIMIT) begin
            cur_bit = tuser[sel];
            old_bit = prev_tuser[sel];
        end
        hit = 1'b0;
        case (cond_e'(cond))
            CND_LOW:  hit = valid && !cur_bit;
            CND_HIGH: hit = valid && cur_bit;
            CND_RISE: hit = valid && cur_bit && !old_bit;
            CND_FALL: hit = valid && !cur_bit && old_bit;
        endcase
    end
endmodule

// File: rtl/tuser_trig_chan.sv
module tuser_trig_chan
    import tuser_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       permit,
    input  logic [1:0] mode,
    input  logic       arm,
    input  logic       clr,
    output logic       fire,
    output logic       status,
    output logic       armed
);
    chan_st_t st_d, st_q;
    mode_e    md;

    assign md = mode_e'(mode);

    always_comb begin
        fire = hit && permit &&
               ((md == MD_CONT) || ((md == MD_ONCE) && st_q.armed));
        st_d = st_q;
        if (fire && (md == MD_ONCE)) st_d.armed = 1'b0;
        if (arm)                     st_d.armed = 1'b1;
        if (clr)                     st_d.status = 1'b0;
        if (fire)                    st_d.status = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
    assign armed  = st_q.armed;
endmodule

// File: rtl/tuser_trig_seq.sv
module tuser_trig_seq
    import tuser_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_fire,
    input  logic fin_fire,
    output logic fin_permit,
    output logic commit,
    output logic align,
    output logic awaiting
);
    seq_st_t sq_d, sq_q;

    always_comb begin
        fin_permit = (sq_q.st == SQ_WAIT_FIN) && !upd_fire;
        sq_d        = sq_q;
        sq_d.commit = upd_fire;
        sq_d.align  = fin_fire;
        if (upd_fire)      sq_d.st = SQ_WAIT_FIN;
        else if (fin_fire) sq_d.st = SQ_WAIT_UPD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{st: SQ_WAIT_UPD, commit: 1'b0, align: 1'b0};
        else        sq_q <= sq_d;
    end

    assign commit   = sq_q.commit;
    assign align    = sq_q.align;
    assign awaiting = (sq_q.st == SQ_WAIT_FIN);
endmodule

// File: rtl/tuser_trig_unit.sv
module tuser_trig_unit
    import tuser_trig_pkg::*;
#(
    parameter  int TUSER_W = 8,
    localparam int IDX_W   = (TUSER_W > 1) ? $clog2(TUSER_W) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_valid,
    input  logic [TUSER_W-1:0] s_tuser,
    input  logic [IDX_W-1:0]   upd_sel,
    input  logic [1:0]         upd_cond,
    input  logic [1:0]         upd_mode,
    input  logic               upd_arm,
    input  logic               upd_clr,
    input  logic [IDX_W-1:0]   fin_sel,
    input  logic [1:0]         fin_cond,
    input  logic [1:0]         fin_mode,
    input  logic               fin_arm,
    input  logic               fin_clr,
    output logic               commit_o,
    output logic               align_o,
    output logic               await_align_o,
    output logic               upd_status_o,
    output logic               fin_status_o,
    output logic               upd_armed_o,
    output logic               fin_armed_o
);
    localparam int NCH = 2;

    logic [TUSER_W-1:0] prev_d, prev_q;

    logic [NCH-1:0][IDX_W-1:0] sel_a;
    logic [NCH-1:0][1:0]       cond_a;
    logic [NCH-1:0][1:0]       mode_a;
    logic [NCH-1:0]            arm_a, clr_a, permit_a;
    logic [NCH-1:0]            hit_a, fire_a, status_a, armed_a;
    logic                      fin_permit;

    // Remembered beat for edge conditions: follows valid beats only.
    always_comb begin
        prev_d = prev_q;
        if (s_valid) prev_d = s_tuser;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // Channel 0 is the update trigger, channel 1 the frame-init trigger.
    assign sel_a    = {fin_sel,  upd_sel};
    assign cond_a   = {fin_cond, upd_cond};
    assign mode_a   = {fin_mode, upd_mode};
    assign arm_a    = {fin_arm,  upd_arm};
    assign clr_a    = {fin_clr,  upd_clr};
    assign permit_a = {fin_permit, 1'b1};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tuser_bit_match #(.TUSER_W(TUSER_W)) u_match (
            .valid      (s_valid),
            .tuser      (s_tuser),
            .prev_tuser (prev_q),
            .sel        (sel_a[c]),
            .cond       (cond_a[c]),
            .hit        (hit_a[c])
        );

        tuser_trig_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit_a[c]),
            .permit (permit_a[c]),
            .mode   (mode_a[c]),
            .arm    (arm_a[c]),
            .clr    (clr_a[c]),
            .fire   (fire_a[c]),
            .status (status_a[c]),
            .armed  (armed_a[c])
        );
    end

    tuser_trig_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_fire   (fire_a[0]),
        .fin_fire   (fire_a[1]),
        .fin_permit (fin_permit),
        .commit     (commit_o),
        .align      (align_o),
        .awaiting   (await_align_o)
    );

    assign upd_status_o = status_a[0];
    assign fin_status_o = status_a[1];
    assign upd_armed_o  = armed_a[0];
    assign fin_armed_o  = armed_a[1];
endmodule

// File: rtl/tuser_trig_chk.sv
module tuser_trig_chk #(
    parameter  int TUSER_W = 8,
    localparam int IDX_W   = (TUSER_W > 1) ? $clog2(TUSER_W) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               s_valid,
    input logic [TUSER_W-1:0] s_tuser,
    input logic [IDX_W-1:0]   upd_sel,
    input logic [1:0]         upd_cond,
    input logic [1:0]         upd_mode,
    input logic               upd_arm,
    input logic               upd_clr,
    input logic [IDX_W-1:0]   fin_sel,
    input logic [1:0]         fin_cond,
    input logic [1:0]         fin_mode,
    input logic               fin_arm,
    input logic               fin_clr,
    input logic               commit_o,
    input logic               align_o,
    input logic               await_align_o,
    input logic               upd_status_o,
    input logic               fin_status_o,
    input logic               upd_armed_o,
    input logic               fin_armed_o
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && align_o)); // R10

    AST_ALIGN_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && align_o |-> $past(await_align_o)); // R9

    AST_COMMIT_AWAITS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> await_align_o); // R9

    AST_ALIGN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        align_o |-> fin_status_o); // R8

    AST_PULSE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && (commit_o || align_o) |-> $past(s_valid)); // R4

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(upd_mode) == 2'd0 || $past(upd_mode) == 2'd3) |-> !commit_o); // R5

    AST_ONCE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && commit_o && $past(upd_mode) == 2'd1 && !$past(upd_arm) |-> !upd_armed_o); // R6

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(upd_status_o) && !$past(upd_clr) |-> upd_status_o); // R7
endmodule

bind tuser_trig_unit tuser_trig_chk #(.TUSER_W(TUSER_W)) u_chk (.*);

// File: tb/sim_tuser_trig_unit.sv
module sim_tuser_trig_unit;
    localparam int TUSER_W = 8;
    localparam int IDX_W   = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               s_valid = 1'b0;
    logic [TUSER_W-1:0] s_tuser = '0;
    logic [IDX_W-1:0]   upd_sel = '0, fin_sel = '0;
    logic [1:0]         upd_cond = '0, upd_mode = '0, fin_cond = '0, fin_mode = '0;
    logic               upd_arm = 1'b0, upd_clr = 1'b0, fin_arm = 1'b0, fin_clr = 1'b0;
    logic commit_o, align_o, await_align_o, upd_status_o, fin_status_o, upd_armed_o, fin_armed_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tuser_trig_unit #(.TUSER_W(TUSER_W)) u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, look just after the rising edge.
    task automatic step(input logic v, input logic [7:0] u,
                        input logic ua = 1'b0, input logic uc = 1'b0,
                        input logic fa = 1'b0, input logic fc = 1'b0);
        @(negedge clk);
        s_valid = v; s_tuser = u;
        upd_arm = ua; upd_clr = uc; fin_arm = fa; fin_clr = fc;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        s_valid = 1'b0; s_tuser = '0;
        upd_arm = 1'b0; upd_clr = 1'b0; fin_arm = 1'b0; fin_clr = 1'b0;
        upd_sel = '0; upd_cond = '0; upd_mode = '0;
        fin_sel = '0; fin_cond = '0; fin_mode = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R11 commit", commit_o, 0);
        check("R11 align", align_o, 0);
        check("R11 await", await_align_o, 0);
        check("R11 upd_status", upd_status_o, 0);
        check("R11 fin_status", fin_status_o, 0);
        check("R11 upd_armed", upd_armed_o, 0);
        check("R11 fin_armed", fin_armed_o, 0);
    endtask

    task automatic t_single_shot();
        do_reset();
        upd_sel = 3'd2; upd_cond = 2'd1; upd_mode = 2'd1;
        step(1'b0, 8'h00, 1'b1);
        check("R6 armed after arm", upd_armed_o, 1);
        step(1'b1, 8'hFB);
        check("R1 other bits ignored", commit_o, 0);
        step(1'b1, 8'h04);
        check("R8 commit pulse", commit_o, 1);
        check("R7 status set", upd_status_o, 1);
        check("R6 disarmed", upd_armed_o, 0);
        check("R9 awaiting align", await_align_o, 1);
        step(1'b1, 8'h04);
        check("R6 no second fire", commit_o, 0);
        check("R7 status sticky", upd_status_o, 1);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        check("R7 status cleared", upd_status_o, 0);
        step(1'b1, 8'h04, 1'b1);
        check("R6 fire with arm", commit_o, 0);
        check("R6 arm wins", upd_armed_o, 1);
        step(1'b1, 8'h04);
        check("R6 rearmed fires", commit_o, 1);
    endtask

    task automatic t_bitsel();
        do_reset();
        upd_sel = 3'd6; upd_cond = 2'd1; upd_mode = 2'd2;
        step(1'b1, 8'hBF);
        check("R1 sel6 bit low", commit_o, 0);
        step(1'b1, 8'h40);
        check("R1 sel6 bit high", commit_o, 1);
        upd_sel = 3'd0;
        step(1'b1, 8'h40);
        check("R1 sel0 ignores bit6", commit_o, 0);
        step(1'b1, 8'h01);
        check("R1 sel0 bit high", commit_o, 1);
    endtask

    task automatic t_edges();
        do_reset();
        upd_sel = 3'd5; upd_cond = 2'd2; upd_mode = 2'd2;
        step(1'b1, 8'h20);
        check("R3 rise from reset zero", commit_o, 1);
        step(1'b1, 8'h20);
        check("R3 held high no rise", commit_o, 0);
        step(1'b0, 8'h00);
        check("R4 invalid beat ignored", commit_o, 0);
        step(1'b1, 8'h20);
        check("R3 invalid beat not remembered", commit_o, 0);
        step(1'b1, 8'h00);
        check("R3 fall under rise cond", commit_o, 0);
        step(1'b1, 8'h20);
        check("R3 rise", commit_o, 1);
        upd_cond = 2'd3;
        step(1'b1, 8'h00);
        check("R3 fall", commit_o, 1);
        step(1'b1, 8'h00);
        check("R3 held low no fall", commit_o, 0);
    endtask

    task automatic t_level_low();
        do_reset();
        upd_sel = 3'd3; upd_cond = 2'd0; upd_mode = 2'd2;
        step(1'b1, 8'hF7);
        check("R2 low level fires", commit_o, 1);
        step(1'b1, 8'h08);
        check("R2 high under low cond", commit_o, 0);
        step(1'b0, 8'h00);
        check("R4 low bit on invalid beat", commit_o, 0);
    endtask

    task automatic t_modes_sticky();
        do_reset();
        upd_sel = 3'd0; upd_cond = 2'd1; upd_mode = 2'd0;
        step(1'b1, 8'h01, 1'b1);
        check("R5 mode0 no commit", commit_o, 0);
        check("R5 mode0 no status", upd_status_o, 0);
        upd_mode = 2'd3;
        step(1'b1, 8'h01);
        check("R5 mode3 no commit", commit_o, 0);
        upd_mode = 2'd2;
        step(1'b1, 8'h01);
        check("R5 cont first", commit_o, 1);
        step(1'b1, 8'h01);
        check("R5 cont second", commit_o, 1);
        step(1'b1, 8'h00, 1'b0, 1'b1);
        check("R7 clear no match", upd_status_o, 0);
        step(1'b1, 8'h01, 1'b0, 1'b1);
        check("R7 set beats clear", upd_status_o, 1);
    endtask

    task automatic t_order();
        do_reset();
        upd_sel = 3'd1; upd_cond = 2'd1; upd_mode = 2'd2;
        fin_sel = 3'd0; fin_cond = 2'd1; fin_mode = 2'd1;
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R6 fin armed", fin_armed_o, 1);
        step(1'b1, 8'h01);
        check("R9 early fin no align", align_o, 0);
        check("R9 early fin no status", fin_status_o, 0);
        check("R9 early fin keeps arm", fin_armed_o, 1);
        step(1'b1, 8'h02);
        check("R8 commit", commit_o, 1);
        check("R9 await after commit", await_align_o, 1);
        step(1'b1, 8'h03);
        check("R10 commit on joint beat", commit_o, 1);
        check("R10 no align on joint beat", align_o, 0);
        check("R10 fin status untouched", fin_status_o, 0);
        check("R10 fin arm kept", fin_armed_o, 1);
        step(1'b1, 8'h01);
        check("R8 align pulse", align_o, 1);
        check("R8 no commit with align", commit_o, 0);
        check("R7 fin status set", fin_status_o, 1);
        check("R6 fin disarmed", fin_armed_o, 0);
        check("R9 await cleared", await_align_o, 0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R8 align one cycle", align_o, 0);
        step(1'b1, 8'h01);
        check("R9 needs new commit", align_o, 0);
        check("R9 arm unused", fin_armed_o, 1);
    endtask

    initial begin
        t_reset();
        t_single_shot();
        t_bitsel();
        t_edges();
        t_level_low();
        t_modes_sticky();
        t_order();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule